// File: doc/BRIEF.md
# Long Byte-String Move and Compare Sequencer

The sequencer carries out long byte-string operations between two regions of a byte-addressed memory. Each operand has an address register and a length register. In a move, operand A is the destination and operand B is the source. In a compare, A is the first operand and B is the second. When the source runs out before the destination is full, the remaining destination bytes take a supplied pad byte. So a move with a zero-length source clears or fills a field. In a compare, the shorter operand is treated as if it were extended with the pad byte until the longer one is exhausted.

A single start pulse launches the operation. Before a move writes anything, the sequencer tests whether the destination would overwrite source bytes that have not yet been read. If it would, nothing is stored and the overlap code is returned. An interrupt request is honoured between byte units. The updated address and length registers stay visible at the ports, so software can restart the operation from them and it carries on exactly where it stopped. Completion is signalled by a one-cycle done pulse together with a 2-bit condition code. The memory is a single-port byte RAM with one cycle of read latency.

Top module: `strmv_engine`

## Requirements
- R1: After reset, busy, done, paused and mem_req are all low and cc reads 0.
- R2: A move stores min(A length, B length) bytes copied in ascending order from B to A, one byte at a time, so that each read sees all earlier writes. It then stores the pad byte in every remaining A byte. No byte outside the A region is written.
- R3: A move that completes returns cc 0 when the two lengths are equal, 1 when A is shorter and 2 when A is longer.
- R4: A move is destructive when A's address is greater than B's address and less than B's address plus the smaller of the two lengths. In that case the sequencer returns cc 3, writes no byte and leaves all four registers unchanged.
- R5: After a completed move, A's address has advanced by A's length and A's length is 0. B's address has advanced by the number of source bytes used, and B's length has dropped by the same number. Each length register falls by at most 1 per clock cycle.
- R6: A compare treats the bytes as unsigned. The shorter operand is extended with the pad byte. The compare returns cc 0 when all bytes are equal, 1 when A's byte is lower at the first difference and 2 when it is higher.
- R7: On a compare mismatch, each address register points at its operand's mismatching byte, or at the end of the operand if that operand is exhausted. Each length register holds the bytes remaining from that point.
- R8: When irq is high before any byte unit except the first one of a run, the sequencer stops and gives a one-cycle paused pulse instead of done. The registers are left holding the position after the last completed unit.
- R9: Relaunching from the register outputs after a pause gives the same final memory, registers and cc as an uninterrupted run. This holds even when irq stays high, because every run completes at least one byte unit.
- R10: A start pulse that arrives while busy is high has no effect on the operation in progress.
- R11: done and paused are single-cycle pulses, are never high together, and busy is low whenever either of them is high.
- R12: mem_we is high only together with mem_req. A compare never writes. mem_req stays low while busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch pulse, sampled only while idle |
| op | input | 1 | Operation select: 0 move, 1 compare |
| irq | input | 1 | Interrupt request, checked between byte units |
| pad | input | 8 | Pad byte |
| a_addr_i | input | ADDR_W | Initial address of operand A |
| a_len_i | input | LEN_W | Initial length of operand A |
| b_addr_i | input | ADDR_W | Initial address of operand B |
| b_len_i | input | LEN_W | Initial length of operand B |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write enable (read when low) |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid one cycle after a read request |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Completion pulse; cc is valid with it |
| paused | output | 1 | Interrupted pulse |
| cc | output | 2 | Condition code |
| a_addr_o | output | ADDR_W | Current address of operand A |
| a_len_o | output | LEN_W | Current length of operand A |
| b_addr_o | output | ADDR_W | Current address of operand B |
| b_len_o | output | LEN_W | Current length of operand B |

## Verification
The bench builds the sequencer with 6-bit addresses and 4-bit lengths over a 64-byte memory. At that size every length pair up to 15 can be combined with destination offsets that sit below, on and above the source, including exactly at the boundary of the destructive window. Compare sweeps cover all sixteen A lengths against several B lengths, under low, high and equal pad bytes, with an injected mismatch that lands either inside or beyond an exhausted operand. Runs with irq held high force a pause after every byte, and the bench resumes each one from the port registers.

// File: rtl/strmv_pkg.sv
package strmv_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_CHECK  = 3'd1,
        ST_STEP   = 3'd2,
        ST_XFER   = 3'd3,
        ST_FETCHB = 3'd4,
        ST_CMP    = 3'd5
    } strmv_state_e;

    localparam logic OP_MOVE    = 1'b0;
    localparam logic OP_COMPARE = 1'b1;

    localparam logic [1:0] CC_EQUAL   = 2'd0;
    localparam logic [1:0] CC_LOW     = 2'd1;
    localparam logic [1:0] CC_HIGH    = 2'd2;
    localparam logic [1:0] CC_OVERLAP = 2'd3;

endpackage

// File: rtl/strmv_order.sv
// Unsigned three-way ordering of two values: 0 equal, 1 lhs lower, 2 lhs higher.
module strmv_order #(
    parameter int W = 8
) (
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    output logic [1:0]   code
);
    import strmv_pkg::*;

    always_comb begin
        if (lhs == rhs) begin
            code = CC_EQUAL;
        end else if (lhs < rhs) begin
            code = CC_LOW;
        end else begin
            code = CC_HIGH;
        end
    end
endmodule

// File: rtl/strmv_overlap.sv
// Flags a move whose destination starts inside the part of the source still to be read.
module strmv_overlap #(
    parameter int ADDR_W = 24,
    parameter int LEN_W  = 24
) (
    input  logic [ADDR_W-1:0] dst_addr,
    input  logic [LEN_W-1:0]  dst_len,
    input  logic [ADDR_W-1:0] src_addr,
    input  logic [LEN_W-1:0]  src_len,
    output logic              destructive
);
    localparam int SUM_W = ((ADDR_W > LEN_W) ? ADDR_W : LEN_W) + 1;

    logic [LEN_W-1:0] short_len;
    logic [SUM_W-1:0] dst_ext;
    logic [SUM_W-1:0] src_ext;
    logic [SUM_W-1:0] src_end;

    assign short_len   = (dst_len < src_len) ? dst_len : src_len;
    assign dst_ext     = SUM_W'(dst_addr);
    assign src_ext     = SUM_W'(src_addr);
    assign src_end     = src_ext + SUM_W'(short_len);
    assign destructive = (dst_ext > src_ext) && (dst_ext < src_end);
endmodule

// File: rtl/strmv_engine.sv
module strmv_engine #(
    parameter int ADDR_W = 24,
    parameter int LEN_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              op,
    input  logic              irq,
    input  logic [7:0]        pad,
    input  logic [ADDR_W-1:0] a_addr_i,
    input  logic [LEN_W-1:0]  a_len_i,
    input  logic [ADDR_W-1:0] b_addr_i,
    input  logic [LEN_W-1:0]  b_len_i,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    output logic              busy,
    output logic              done,
    output logic              paused,
    output logic [1:0]        cc,
    output logic [ADDR_W-1:0] a_addr_o,
    output logic [LEN_W-1:0]  a_len_o,
    output logic [ADDR_W-1:0] b_addr_o,
    output logic [LEN_W-1:0]  b_len_o
);
    import strmv_pkg::*;

    localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(1);
    localparam logic [LEN_W-1:0]  LEN_STEP  = LEN_W'(1);

    typedef struct packed {
        strmv_state_e      st;
        logic              op;
        logic [ADDR_W-1:0] a_addr;
        logic [LEN_W-1:0]  a_len;
        logic [ADDR_W-1:0] b_addr;
        logic [LEN_W-1:0]  b_len;
        logic [7:0]        pad;
        logic [7:0]        hold;
        logic              progressed;
        logic [1:0]        cc;
        logic              done;
        logic              paused;
    } regs_t;

    regs_t q, d;

    logic       a_nz;
    logic       b_nz;
    logic       finished;
    logic       overlap_hit;
    logic [1:0] len_code;
    logic [1:0] byte_code;
    logic [7:0] byte_b;

    assign a_nz     = (q.a_len != '0);
    assign b_nz     = (q.b_len != '0);
    assign finished = (q.op == OP_MOVE) ? !a_nz : (!a_nz && !b_nz);
    assign byte_b   = b_nz ? mem_rdata : q.pad;

    strmv_overlap #(
        .ADDR_W(ADDR_W),
        .LEN_W (LEN_W)
    ) u_overlap (
        .dst_addr   (q.a_addr),
        .dst_len    (q.a_len),
        .src_addr   (q.b_addr),
        .src_len    (q.b_len),
        .destructive(overlap_hit)
    );

    strmv_order #(.W(LEN_W)) u_len_order (
        .lhs (q.a_len),
        .rhs (q.b_len),
        .code(len_code)
    );

    strmv_order #(.W(8)) u_byte_order (
        .lhs (q.hold),
        .rhs (byte_b),
        .code(byte_code)
    );

    always_comb begin
        d          = q;
        d.done     = 1'b0;
        d.paused   = 1'b0;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = q.a_addr;
        mem_wdata  = q.pad;

        unique case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.op         = op;
                    d.a_addr     = a_addr_i;
                    d.a_len      = a_len_i;
                    d.b_addr     = b_addr_i;
                    d.b_len      = b_len_i;
                    d.pad        = pad;
                    d.progressed = 1'b0;
                    d.cc         = CC_EQUAL;
                    d.st         = ST_CHECK;
                end
            end

            ST_CHECK: begin
                if (q.op == OP_MOVE && overlap_hit) begin
                    d.cc   = CC_OVERLAP;
                    d.done = 1'b1;
                    d.st   = ST_IDLE;
                end else begin
                    if (q.op == OP_MOVE) begin
                        d.cc = len_code;
                    end
                    d.st = ST_STEP;
                end
            end

            ST_STEP: begin
                if (finished) begin
                    d.done = 1'b1;
                    d.st   = ST_IDLE;
                end else if (q.progressed && irq) begin
                    d.paused = 1'b1;
                    d.st     = ST_IDLE;
                end else if (q.op == OP_MOVE) begin
                    if (b_nz) begin
                        mem_req  = 1'b1;
                        mem_addr = q.b_addr;
                    end
                    d.st = ST_XFER;
                end else begin
                    if (a_nz) begin
                        mem_req  = 1'b1;
                        mem_addr = q.a_addr;
                    end
                    d.st = ST_FETCHB;
                end
            end

            ST_XFER: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = q.a_addr;
                mem_wdata = b_nz ? mem_rdata : q.pad;
                d.a_addr  = q.a_addr + ADDR_STEP;
                d.a_len   = q.a_len - LEN_STEP;
                if (b_nz) begin
                    d.b_addr = q.b_addr + ADDR_STEP;
                    d.b_len  = q.b_len - LEN_STEP;
                end
                d.progressed = 1'b1;
                d.st         = ST_STEP;
            end

            ST_FETCHB: begin
                d.hold = a_nz ? mem_rdata : q.pad;
                if (b_nz) begin
                    mem_req  = 1'b1;
                    mem_addr = q.b_addr;
                end
                d.st = ST_CMP;
            end

            ST_CMP: begin
                if (byte_code != CC_EQUAL) begin
                    d.cc   = byte_code;
                    d.done = 1'b1;
                    d.st   = ST_IDLE;
                end else begin
                    if (a_nz) begin
                        d.a_addr = q.a_addr + ADDR_STEP;
                        d.a_len  = q.a_len - LEN_STEP;
                    end
                    if (b_nz) begin
                        d.b_addr = q.b_addr + ADDR_STEP;
                        d.b_len  = q.b_len - LEN_STEP;
                    end
                    d.progressed = 1'b1;
                    d.st         = ST_STEP;
                end
            end

            default: begin
                d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy     = (q.st != ST_IDLE);
    assign done     = q.done;
    assign paused   = q.paused;
    assign cc       = q.cc;
    assign a_addr_o = q.a_addr;
    assign a_len_o  = q.a_len;
    assign b_addr_o = q.b_addr;
    assign b_len_o  = q.b_len;
endmodule

// File: rtl/strmv_engine_chk.sv
module strmv_engine_chk #(
    parameter int ADDR_W = 24,
    parameter int LEN_W  = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              op,
    input logic              busy,
    input logic              done,
    input logic              paused,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] a_addr_o,
    input logic [LEN_W-1:0]  a_len_o,
    input logic [ADDR_W-1:0] b_addr_o,
    input logic [LEN_W-1:0]  b_len_o
);
    logic op_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_seen <= 1'b0;
        end else if (start && !busy) begin
            op_seen <= op;
        end
    end

    assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_pulse_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && paused));

    assert_idle_on_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (done || paused) |-> !busy);

    assert_write_has_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_req);

    assert_compare_no_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && op_seen) |-> !mem_we);

    assert_idle_no_access_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    assert_pause_keeps_regs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        paused |-> ($stable(a_addr_o) && $stable(a_len_o) && $stable(b_addr_o) && $stable(b_len_o)));

    assert_len_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |->
            ((a_len_o == $past(a_len_o) || (a_len_o + LEN_W'(1)) == $past(a_len_o)) &&
             (b_len_o == $past(b_len_o) || (b_len_o + LEN_W'(1)) == $past(b_len_o))));
endmodule

bind strmv_engine strmv_engine_chk #(
    .ADDR_W(ADDR_W),
    .LEN_W (LEN_W)
) u_strmv_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .op      (op),
    .busy    (busy),
    .done    (done),
    .paused  (paused),
    .mem_req (mem_req),
    .mem_we  (mem_we),
    .a_addr_o(a_addr_o),
    .a_len_o (a_len_o),
    .b_addr_o(b_addr_o),
    .b_len_o (b_len_o)
);

// File: tb/test_strmv_engine.sv
`timescale 1ns/1ps
module test_strmv_engine;
    localparam int AW  = 6;
    localparam int LW  = 4;
    localparam int MSZ = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          op = 1'b0;
    logic          irq = 1'b0;
    logic [7:0]    pad = 8'h00;
    logic [AW-1:0] a_addr_i = '0;
    logic [LW-1:0] a_len_i = '0;
    logic [AW-1:0] b_addr_i = '0;
    logic [LW-1:0] b_len_i = '0;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;
    logic [7:0]    mem_rdata;
    logic          busy, done, paused;
    logic [1:0]    cc;
    logic [AW-1:0] a_addr_o, b_addr_o;
    logic [LW-1:0] a_len_o, b_len_o;

    logic          tb_we = 1'b0;
    logic [AW-1:0] tb_addr = '0;
    logic [7:0]    tb_wd = 8'h00;

    logic [7:0] mem [MSZ];
    logic [7:0] ref_mem [MSZ];

    int n_vec = 0;
    int n_bad = 0;

    int exp_cc, exp_aa, exp_al, exp_ba, exp_bl;

    always #2 clk = ~clk;

    always_ff @(posedge clk) begin
        if (tb_we) begin
            mem[tb_addr] <= tb_wd;
        end else if (mem_req && mem_we) begin
            mem[mem_addr] <= mem_wdata;
        end
        if (mem_req && !mem_we) begin
            mem_rdata <= mem[mem_addr];
        end
    end

    strmv_engine #(.ADDR_W(AW), .LEN_W(LW)) i_strmv_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .irq(irq), .pad(pad),
        .a_addr_i(a_addr_i), .a_len_i(a_len_i), .b_addr_i(b_addr_i), .b_len_i(b_len_i),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .busy(busy), .done(done), .paused(paused), .cc(cc),
        .a_addr_o(a_addr_o), .a_len_o(a_len_o), .b_addr_o(b_addr_o), .b_len_o(b_len_o)
    );

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run hung, got timeout expected completion");
        summary();
        $finish;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] fval(input int mode, input int i, input int seed);
        if (mode == 0) return 8'((i * 7) + (seed * 13) + 1);
        if (mode == 1) return 8'(((i & 15) * 5) + 1);
        return 8'h20;
    endfunction

    task automatic fill(input int mode, input int seed);
        for (int i = 0; i < MSZ; i++) begin
            @(negedge clk);
            tb_we = 1'b1; tb_addr = AW'(i); tb_wd = fval(mode, i, seed);
            ref_mem[i] = fval(mode, i, seed);
        end
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    task automatic poke(input int addr, input logic [7:0] val);
        @(negedge clk);
        tb_we = 1'b1; tb_addr = AW'(addr); tb_wd = val;
        ref_mem[addr] = val;
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    task automatic launch(input logic o, input int aa, input int al, input int ba, input int bl,
                          input logic [7:0] p);
        @(negedge clk);
        start = 1'b1; op = o; pad = p;
        a_addr_i = AW'(aa); a_len_i = LW'(al); b_addr_i = AW'(ba); b_len_i = LW'(bl);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_end(output bit ended_done);
        int t = 0;
        while (!(done || paused) && t < 400) begin
            @(negedge clk);
            t++;
        end
        chk("R11", "end pulse seen", int'(done || paused), 1);
        ended_done = done;
    endtask

    task automatic ref_move(input int da, input int dl, input int sa, input int sl, input logic [7:0] p);
        int minl = (dl < sl) ? dl : sl;
        if (da > sa && da < sa + minl) begin
            exp_cc = 3; exp_aa = da; exp_al = dl; exp_ba = sa; exp_bl = sl;
        end else begin
            exp_cc = (dl == sl) ? 0 : ((dl < sl) ? 1 : 2);
            for (int k = 0; k < dl; k++) begin
                ref_mem[da + k] = (k < sl) ? ref_mem[sa + k] : p;
            end
            exp_aa = (da + dl) % MSZ; exp_al = 0; exp_ba = (sa + minl) % MSZ; exp_bl = sl - minl;
        end
    endtask

    task automatic ref_cmp(input int aa, input int al, input int ba, input int bl, input logic [7:0] p);
        int mx = (al > bl) ? al : bl;
        exp_cc = 0; exp_aa = aa + al; exp_al = 0; exp_ba = ba + bl; exp_bl = 0;
        for (int k = 0; k < mx; k++) begin
            logic [7:0] x, y;
            x = (k < al) ? ref_mem[aa + k] : p;
            y = (k < bl) ? ref_mem[ba + k] : p;
            if (x != y) begin
                int ua = (k < al) ? k : al;
                int ub = (k < bl) ? k : bl;
                exp_cc = (x < y) ? 1 : 2;
                exp_aa = aa + ua; exp_al = al - ua; exp_ba = ba + ub; exp_bl = bl - ub;
                break;
            end
        end
    endtask

    task automatic check_result(input string rcc, input string rreg, input string rmem);
        int bad = 0;
        chk(rcc, "cc", int'(cc), exp_cc);
        chk(rreg, "a_addr", int'(a_addr_o), exp_aa);
        chk(rreg, "a_len", int'(a_len_o), exp_al);
        chk(rreg, "b_addr", int'(b_addr_o), exp_ba);
        chk(rreg, "b_len", int'(b_len_o), exp_bl);
        for (int i = 0; i < MSZ; i++) if (mem[i] != ref_mem[i]) bad++;
        chk(rmem, "memory bytes differing", bad, 0);
    endtask

    initial begin
        int dsts [7] = '{10, 13, 16, 19, 22, 25, 28};
        int blens [4] = '{0, 3, 9, 15};
        bit fin;
        int pauses;
        int seed = 0;

        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "busy", int'(busy), 0);
        chk("R1", "done", int'(done), 0);
        chk("R1", "paused", int'(paused), 0);
        chk("R1", "mem_req", int'(mem_req), 0);
        chk("R1", "cc", int'(cc), 0);
        rst_n = 1'b1;

        // R2 R3 R4 R5: move sweep around source at 16, lengths 0..15 step 3
        for (int di = 0; di < 7; di++) begin
            for (int al = 0; al < 16; al += 3) begin
                for (int bl = 0; bl < 16; bl += 3) begin
                    logic [7:0] p = 8'hA0 + 8'(seed);
                    fill(0, seed);
                    launch(1'b0, dsts[di], al, 16, bl, p);
                    ref_move(dsts[di], al, 16, bl, p);
                    wait_end(fin);
                    chk("R3", "ended with done", int'(fin), 1);
                    if (exp_cc == 3) check_result("R4", "R4", "R4");
                    else check_result("R3", "R5", "R2");
                    seed++;
                end
            end
        end

        // R6 R7: compare sweep, A at 0, B at 32
        for (int mode = 0; mode < 4; mode++) begin
            for (int al = 0; al < 16; al++) begin
                for (int bi = 0; bi < 4; bi++) begin
                    logic [7:0] p = (mode == 0) ? 8'h00 : ((mode == 1) ? 8'hFF : 8'h20);
                    fill((mode < 2) ? 1 : 2, 0);
                    if (mode == 3) poke(35, 8'h10);
                    launch(1'b1, 0, al, 32, blens[bi], p);
                    ref_cmp(0, al, 32, blens[bi], p);
                    wait_end(fin);
                    chk("R6", "ended with done", int'(fin), 1);
                    check_result("R6", "R7", "R12");
                end
            end
        end

        // R8 R9: move with irq held high, resumed from port registers
        fill(0, 99);
        irq = 1'b1;
        launch(1'b0, 40, 9, 16, 5, 8'h5A);
        ref_move(40, 9, 16, 5, 8'h5A);
        pauses = 0;
        wait_end(fin);
        chk("R8", "first run paused", int'(paused), 1);
        chk("R8", "a_addr after one unit", int'(a_addr_o), 41);
        chk("R8", "a_len after one unit", int'(a_len_o), 8);
        chk("R8", "b_addr after one unit", int'(b_addr_o), 17);
        chk("R8", "b_len after one unit", int'(b_len_o), 4);
        while (!fin && pauses < 40) begin
            pauses++;
            launch(1'b0, int'(a_addr_o), int'(a_len_o), int'(b_addr_o), int'(b_len_o), 8'h5A);
            wait_end(fin);
        end
        chk("R9", "pauses for 9-byte move", pauses, 8);
        check_result("R9", "R9", "R9");

        // R9: shorter destination, irq held
        fill(0, 7);
        launch(1'b0, 2, 5, 30, 9, 8'h11);
        ref_move(2, 5, 30, 9, 8'h11);
        pauses = 0;
        wait_end(fin);
        while (!fin && pauses < 40) begin
            pauses++;
            launch(1'b0, int'(a_addr_o), int'(a_len_o), int'(b_addr_o), int'(b_len_o), 8'h11);
            wait_end(fin);
        end
        chk("R9", "pauses for 5-byte move", pauses, 4);
        check_result("R9", "R9", "R9");

        // R8 R9: compare with mismatch at byte 3, irq held
        fill(2, 0);
        poke(35, 8'h10);
        launch(1'b1, 0, 8, 32, 8, 8'h20);
        ref_cmp(0, 8, 32, 8, 8'h20);
        pauses = 0;
        wait_end(fin);
        while (!fin && pauses < 40) begin
            pauses++;
            launch(1'b1, int'(a_addr_o), int'(a_len_o), int'(b_addr_o), int'(b_len_o), 8'h20);
            wait_end(fin);
        end
        chk("R8", "pauses before mismatch", pauses, 3);
        check_result("R9", "R7", "R9");
        irq = 1'b0;

        // R10: start while busy is ignored
        fill(0, 3);
        launch(1'b0, 40, 12, 0, 12, 8'h00);
        ref_move(40, 12, 0, 12, 8'h00);
        repeat (4) @(negedge clk);
        chk("R10", "busy during run", int'(busy), 1);
        start = 1'b1; op = 1'b1; a_addr_i = AW'(5); a_len_i = LW'(2); b_addr_i = AW'(6); b_len_i = LW'(3);
        @(negedge clk);
        start = 1'b0;
        wait_end(fin);
        chk("R10", "ended with done", int'(fin), 1);
        check_result("R10", "R10", "R10");
        @(negedge clk);
        chk("R11", "done one cycle", int'(done), 0);
        chk("R11", "idle after done", int'(busy), 0);

        summary();
        $finish;
    end
endmodule